// File: doc/BRIEF.md
# Expansion Bus Memory-Module Responder

This block is the slave-side front end of a plug-in memory card on a 16-bit expansion bus with 23 word-address lines. Memory cards do not use the per-slot select lines that I/O cards use. They watch the global active-low address strobe and decode every cycle themselves. Each bus input passes through a two-stage synchronizer. The responder detects the start of a cycle on the falling edge of the synchronized strobe. It then compares the top four address bits against a window base held in an allocation register.

If the address is owned, the block pulls its "claimed" line low at once. It then serves the access to a small internal RAM with byte-lane granularity and pulls the acknowledge low. Read data is driven on the enabled byte lanes, valid from the same cycle as the acknowledge. Write data is captured well before the acknowledge. Both strobes return high shortly after the host lifts the address strobe.

The allocation register is loaded through a three-signal configuration port. This port stands in for the allocation procedure, which lies outside this block. A module that has never been allocated, or that has been de-allocated, ignores every bus cycle.

Top module: `xbus_mem_responder`

## Requirements
- R1: After reset `bus_claim_n` and `bus_ack_n` are high, `bus_data_oe` is 0, and the module is unallocated.
- R2: While the allocation enable is 0, no bus cycle causes `bus_claim_n` or `bus_ack_n` to go low, and no byte lane is driven.
- R3: When allocated, a cycle is owned only if address bits [23:20] equal the 4-bit window base. A cycle outside the window leaves `bus_claim_n`, `bus_ack_n` and `bus_data_oe` inactive throughout.
- R4: Count the rising clock edges from the first one at which `bus_as_n` is sampled low. For an owned cycle, `bus_claim_n` goes low after the third such edge and `bus_ack_n` goes low after the fourth.
- R5: On an owned read, `bus_data_out` holds the addressed RAM word from the cycle in which `bus_ack_n` falls. It stays stable while `bus_ack_n` is low. The RAM word index is address bits [6:1] (64 words).
- R6: On an owned write, `bus_uds_n` low writes data bits [15:8] and `bus_lds_n` low writes bits [7:0]. A lane whose strobe is high keeps its old contents. Write data must be valid when `bus_as_n` falls.
- R7: `bus_data_oe` bit 1 (upper lane, bits [15:8]) and bit 0 (lower lane, bits [7:0]) are set only during an owned read while `bus_ack_n` is low, and only for lanes whose strobe was low.
- R8: Count the rising clock edges from the first one at which `bus_as_n` is sampled high again. `bus_claim_n` and `bus_ack_n` return high after the third such edge, and `bus_data_oe` returns to 0 at the same edge.
- R9: Within the owned 1 MB window, address bits [19:7] are ignored. Two addresses that differ only there reach the same RAM word.
- R10: Pulsing `cfg_load` replaces the enable and base. The next cycle answers in the new window only, and RAM contents are retained.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load pulse for the allocation register |
| cfg_enable | input | 1 | Allocation enable value to load |
| cfg_base | input | 4 | Window base value to load (address bits [23:20]) |
| bus_as_n | input | 1 | Active-low address strobe |
| bus_addr | input | 23 | Word address, bits [23:1] |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_uds_n | input | 1 | Active-low upper byte strobe |
| bus_lds_n | input | 1 | Active-low lower byte strobe |
| bus_data_in | input | 16 | Write data from host |
| bus_data_out | output | 16 | Read data to host |
| bus_data_oe | output | 2 | Per-lane output enable, bit 1 upper |
| bus_claim_n | output | 1 | Active-low "this module is addressed" |
| bus_ack_n | output | 1 | Active-low data-transfer acknowledge |

## Verification
The hardest situations to reach are those tied to the allocation state. These are a partial-lane write landing on a word that already holds data, and an address that aliases inside the window after the window has moved. Neither shows up in a single bus cycle. The stimulus therefore chains cycles: a full write, a single-lane overwrite, reads with each lane pattern, and then a reload of the base that must make the old window silent and the new window return the retained word.

// File: rtl/xbus_mem_pkg.sv
package xbus_mem_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_ACK  = 2'd2
    } resp_state_e;

    localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/xbus_sync.sv
module xbus_sync #(
    parameter int unsigned    W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = d;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            r_q <= r_d;
        end
    end

    assign q = r_q.s2;

endmodule

// File: rtl/xbus_window.sv
module xbus_window #(
    parameter int unsigned BASE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              cfg_enable,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic [BASE_W-1:0] probe_hi,
    output logic              owned
);

    typedef struct packed {
        logic              en;
        logic [BASE_W-1:0] base;
    } win_t;

    win_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (cfg_load) begin
            w_d.en   = cfg_enable;
            w_d.base = cfg_base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '{en: 1'b0, base: '0};
        end else begin
            w_q <= w_d;
        end
    end

    assign owned = w_q.en && (probe_hi == w_q.base);

endmodule

// File: rtl/xbus_lane_ram.sv
module xbus_lane_ram #(
    parameter int unsigned WORDS  = 64,
    parameter int unsigned LANES  = 2,
    parameter int unsigned IDX_W  = $clog2(WORDS),
    parameter int unsigned DATA_W = LANES * xbus_mem_pkg::LANE_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LANES-1:0]  lane_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    import xbus_mem_pkg::*;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [WORDS];

        always_ff @(posedge clk) begin
            if (we && lane_en[b]) begin
                lane_mem[idx] <= wdata[b*LANE_W +: LANE_W];
            end
        end

        assign rdata[b*LANE_W +: LANE_W] = lane_mem[idx];
    end

endmodule

// File: rtl/xbus_mem_responder.sv
module xbus_mem_responder #(
    parameter int unsigned ADDR_W    = 23,
    parameter int unsigned BASE_W    = 4,
    parameter int unsigned RAM_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              cfg_enable,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic              bus_as_n,
    input  logic [ADDR_W:1]   bus_addr,
    input  logic              bus_rnw,
    input  logic              bus_uds_n,
    input  logic              bus_lds_n,
    input  logic [15:0]       bus_data_in,
    output logic [15:0]       bus_data_out,
    output logic [1:0]        bus_data_oe,
    output logic              bus_claim_n,
    output logic              bus_ack_n
);
    import xbus_mem_pkg::*;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned LANES  = DATA_W / LANE_W;
    localparam int unsigned IDX_W  = $clog2(RAM_WORDS);
    localparam int unsigned SYNC_W = 4 + ADDR_W + DATA_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {4'b1011, {(ADDR_W + DATA_W){1'b0}}};

    // synchronized bus view
    logic [SYNC_W-1:0] sync_q;
    logic              as_s, rnw_s, uds_s, lds_s;
    logic [ADDR_W:1]   addr_s;
    logic [DATA_W-1:0] data_s;

    xbus_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_as_n, bus_rnw, bus_uds_n, bus_lds_n, bus_addr, bus_data_in}),
        .q     (sync_q)
    );

    assign {as_s, rnw_s, uds_s, lds_s, addr_s, data_s} = sync_q;

    // address bits inside the window above the RAM index are don't-care (aliasing)
    logic unused_mid_bits;
    assign unused_mid_bits = ^addr_s[ADDR_W-BASE_W:IDX_W+1];

    logic owned;

    xbus_window #(.BASE_W(BASE_W)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .cfg_enable (cfg_enable),
        .cfg_base   (cfg_base),
        .probe_hi   (addr_s[ADDR_W -: BASE_W]),
        .owned      (owned)
    );

    typedef struct packed {
        resp_state_e       st;
        logic              as_prev;
        logic              claim;
        logic              ack;
        logic              rnw;
        logic [LANES-1:0]  lane;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } resp_t;

    resp_t r_d, r_q;

    logic              ram_we;
    logic [DATA_W-1:0] ram_rd;

    xbus_lane_ram #(
        .WORDS  (RAM_WORDS),
        .LANES  (LANES),
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_ram (
        .clk     (clk),
        .we      (ram_we),
        .lane_en (r_q.lane),
        .idx     (r_q.idx),
        .wdata   (r_q.wdata),
        .rdata   (ram_rd)
    );

    logic as_fall;
    assign as_fall = !as_s && r_q.as_prev;

    always_comb begin
        r_d         = r_q;
        r_d.as_prev = as_s;
        ram_we      = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (as_fall && owned) begin
                    r_d.st    = ST_ADDR;
                    r_d.claim = 1'b1;
                    r_d.rnw   = rnw_s;
                    r_d.lane  = ~{uds_s, lds_s};
                    r_d.idx   = addr_s[IDX_W:1];
                    r_d.wdata = data_s;
                end
            end
            ST_ADDR: begin
                r_d.st  = ST_ACK;
                r_d.ack = 1'b1;
                if (r_q.rnw) begin
                    r_d.rdata = ram_rd;
                end else begin
                    ram_we = 1'b1;
                end
            end
            ST_ACK: begin
                if (as_s) begin
                    r_d.st    = ST_IDLE;
                    r_d.claim = 1'b0;
                    r_d.ack   = 1'b0;
                end
            end
            default: begin
                r_d.st    = ST_IDLE;
                r_d.claim = 1'b0;
                r_d.ack   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, as_prev: 1'b1, claim: 1'b0, ack: 1'b0,
                     rnw: 1'b1, lane: '0, idx: '0, wdata: '0, rdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_claim_n  = ~r_q.claim;
    assign bus_ack_n    = ~r_q.ack;
    assign bus_data_out = r_q.rdata;
    assign bus_data_oe  = (r_q.st == ST_ACK && r_q.rnw) ? r_q.lane : '0;

endmodule

// File: rtl/xbus_mem_responder_chk.sv
module xbus_mem_responder_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              as_sync,
    input logic              claim_n,
    input logic              ack_n,
    input logic [1:0]        data_oe,
    input logic [DATA_W-1:0] data_out
);

    // R4: acknowledge only while claimed
    a_r4_ack_within_claim: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> !claim_n);

    // R4: claim precedes the acknowledge edge
    a_r4_claim_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> $past(!claim_n));

    // R7: lanes driven only during acknowledge
    a_r7_oe_only_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe != 2'b00) |-> !ack_n);

    // R5: read data holds while acknowledged
    a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && $past(!ack_n)) |-> $stable(data_out));

    // R8: strobe high for three samples means released
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (as_sync && $past(as_sync) && $past(as_sync, 2)) |-> (claim_n && ack_n));

endmodule

bind xbus_mem_responder xbus_mem_responder_chk #(.DATA_W(16)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .as_sync  (as_s),
    .claim_n  (bus_claim_n),
    .ack_n    (bus_ack_n),
    .data_oe  (bus_data_oe),
    .data_out (bus_data_out)
);

// File: tb/xbus_mem_responder_bench.sv
module xbus_mem_responder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [3:0]  cfg_base = 4'h0;
    logic        bus_as_n = 1'b1;
    logic [23:1] bus_addr = '0;
    logic        bus_rnw = 1'b1;
    logic        bus_uds_n = 1'b1;
    logic        bus_lds_n = 1'b1;
    logic [15:0] bus_data_in = '0;
    logic [15:0] bus_data_out;
    logic [1:0]  bus_data_oe;
    logic        bus_claim_n;
    logic        bus_ack_n;

    always #2.5 clk = ~clk;

    xbus_mem_responder u_xbus_mem_responder (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_load     (cfg_load),
        .cfg_enable   (cfg_enable),
        .cfg_base     (cfg_base),
        .bus_as_n     (bus_as_n),
        .bus_addr     (bus_addr),
        .bus_rnw      (bus_rnw),
        .bus_uds_n    (bus_uds_n),
        .bus_lds_n    (bus_lds_n),
        .bus_data_in  (bus_data_in),
        .bus_data_out (bus_data_out),
        .bus_data_oe  (bus_data_oe),
        .bus_claim_n  (bus_claim_n),
        .bus_ack_n    (bus_ack_n)
    );

    int   n_vec  = 0;
    int   n_miss = 0;
    bit   done   = 0;

    // behavioural reference state
    bit          m_en   = 0;
    logic [3:0]  m_base = 4'h0;
    logic [15:0] m_mem [int];

    function automatic logic [23:1] mk_addr(input logic [3:0] win, input int word);
        return {win, 19'(word)};
    endfunction

    task automatic cmp(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic configure(input bit en, input logic [3:0] base);
        cfg_load = 1'b1; cfg_enable = en; cfg_base = base;
        @(posedge clk); @(negedge clk);
        cfg_load = 1'b0;
        m_en = en; m_base = base;
    endtask

    task automatic outputs_check(input string tag, input bit claim, input bit ack,
                                 input logic [1:0] oe, input logic [15:0] rd);
        cmp(tag, "claim_n", {15'd0, bus_claim_n}, {15'd0, !claim});
        cmp(tag, "ack_n",   {15'd0, bus_ack_n},   {15'd0, !ack});
        cmp("R7", "data_oe", {14'd0, bus_data_oe}, {14'd0, oe});
        if (oe[1]) cmp("R5", "data_hi", {8'd0, bus_data_out[15:8]}, {8'd0, rd[15:8]});
        if (oe[0]) cmp("R5", "data_lo", {8'd0, bus_data_out[7:0]},  {8'd0, rd[7:0]});
    endtask

    // one full bus cycle, compared on every clock against the model
    task automatic bus_cycle(input string tag, input logic [23:1] a, input bit rnw,
                             input bit uds_n, input bit lds_n, input logic [15:0] wd);
        bit          own;
        int          w;
        logic [1:0]  lanes;
        logic [15:0] rd;
        logic [1:0]  oe_on;
        own   = m_en && (a[23:20] == m_base);
        w     = int'(a[6:1]);
        lanes = {!uds_n, !lds_n};
        rd    = m_mem.exists(w) ? m_mem[w] : 16'h0000;
        oe_on = (own && rnw) ? lanes : 2'b00;
        bus_addr = a; bus_rnw = rnw; bus_uds_n = uds_n; bus_lds_n = lds_n;
        bus_data_in = wd; bus_as_n = 1'b0;
        for (int j = 1; j <= 6; j++) begin
            @(posedge clk); @(negedge clk);
            outputs_check(tag, own && j >= 3, own && j >= 4, (j >= 4) ? oe_on : 2'b00, rd);
        end
        bus_as_n = 1'b1;
        for (int r = 1; r <= 4; r++) begin
            @(posedge clk); @(negedge clk);
            outputs_check("R8", own && r < 3, own && r < 3, (r < 3) ? oe_on : 2'b00, rd);
        end
        if (own && !rnw) begin
            logic [15:0] old;
            old = m_mem.exists(w) ? m_mem[w] : 16'h0000;
            if (lanes[1]) old[15:8] = wd[15:8];
            if (lanes[0]) old[7:0]  = wd[7:0];
            m_mem[w] = old;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        cmp("R1", "claim_n", {15'd0, bus_claim_n}, 16'd1);
        cmp("R1", "ack_n",   {15'd0, bus_ack_n},   16'd1);
        cmp("R1", "data_oe", {14'd0, bus_data_oe}, 16'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1/R2: unallocated after reset ignores a write
        bus_cycle("R2", mk_addr(4'h0, 5), 1'b0, 1'b0, 1'b0, 16'hDEAD);

        configure(1'b1, 4'h3);
        // R6: full write, then R5 read back
        bus_cycle("R6", mk_addr(4'h3, 5), 1'b0, 1'b0, 1'b0, 16'hA1B2);
        bus_cycle("R4", mk_addr(4'h3, 5), 1'b1, 1'b0, 1'b0, 16'h0000);
        // R6: upper lane only keeps lower byte
        bus_cycle("R6", mk_addr(4'h3, 5), 1'b0, 1'b0, 1'b1, 16'hCC77);
        bus_cycle("R6", mk_addr(4'h3, 5), 1'b1, 1'b0, 1'b0, 16'h0000);
        // R6: lower lane only on another word
        bus_cycle("R6", mk_addr(4'h3, 9), 1'b0, 1'b0, 1'b0, 16'h1234);
        bus_cycle("R6", mk_addr(4'h3, 9), 1'b0, 1'b1, 1'b0, 16'hFF56);
        // R7: single-lane reads
        bus_cycle("R7", mk_addr(4'h3, 9), 1'b1, 1'b1, 1'b0, 16'h0000);
        bus_cycle("R7", mk_addr(4'h3, 9), 1'b1, 1'b0, 1'b1, 16'h0000);
        // R3: outside the window
        bus_cycle("R3", mk_addr(4'h4, 5), 1'b1, 1'b0, 1'b0, 16'h0000);
        bus_cycle("R3", mk_addr(4'h2, 5), 1'b0, 1'b0, 1'b0, 16'h5555);
        // R9: alias via bits above the RAM index
        bus_cycle("R9", mk_addr(4'h3, 5 + 64), 1'b1, 1'b0, 1'b0, 16'h0000);
        bus_cycle("R9", mk_addr(4'h3, 9 + 4096), 1'b1, 1'b0, 1'b0, 16'h0000);

        // R10: move the window, contents retained
        configure(1'b1, 4'h9);
        bus_cycle("R10", mk_addr(4'h3, 5), 1'b1, 1'b0, 1'b0, 16'h0000);
        bus_cycle("R10", mk_addr(4'h9, 5), 1'b1, 1'b0, 1'b0, 16'h0000);
        bus_cycle("R10", mk_addr(4'hF, 9), 1'b1, 1'b0, 1'b0, 16'h0000);

        // R2: de-allocated module stays silent
        configure(1'b0, 4'h9);
        bus_cycle("R2", mk_addr(4'h9, 5), 1'b1, 1'b0, 1'b0, 16'h0000);
        bus_cycle("R2", mk_addr(4'h9, 9), 1'b0, 1'b0, 1'b0, 16'h4321);
        // ensure the ignored write did not land
        configure(1'b1, 4'h9);
        bus_cycle("R2", mk_addr(4'h9, 9), 1'b1, 1'b0, 1'b0, 16'h0000);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_vec++;
            n_miss++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

endmodule